// File: doc/BRIEF.md
# Wait-Timeout Interrupt Status Unit

This block holds the interrupt status for an external asynchronous memory controller. It records three kinds of event as sticky raw flags. The first is a rising edge on the active-low wait input, after that input has been synchronized. The second is a one-cycle line-trap pulse, which reports an illegal access type or a bad cache line size. The third is a timeout: during an extended access, the wait input stayed asserted for longer than a programmed number of cycles.

Software reads these flags over a simple register bus and clears them by writing ones. An enable word gates the flags onto a masked status word and onto a single interrupt line. The enable word is changed through separate set and clear addresses. A flag always latches its event, whether or not it is enabled. Clearing a raw flag also clears its masked copy.

Top module: `wait_tmo_irq`

## Requirements
- R1: After reset, the raw flags, the enables and the interrupt output are all 0.
- R2: The raw status word is at address 0x40. Bit 0 is the timeout flag, bit 1 is the line-trap flag and bit 2 is the wait-rise flag. Bits 31:3 read as 0, and writes to them change nothing.
- R3: Writing 1 to a raw bit at 0x40 clears that bit. Writing 0 leaves it unchanged. A clear also removes the bit from the masked word at 0x4C.
- R4: A raw flag is set by its event even when its enable is 0.
- R5: The wait input passes through two synchronizer flops. A change of the synchronized value from 0 to 1 sets bit 2. Bit 2 is visible after the third rising clock edge that follows the input rising.
- R6: A high `trap_pulse` at a clock edge sets bit 1.
- R7: During an access (`ext_access` high), let the synchronized wait input be low at N consecutive edges. Bit 0 sets at edge N = `max_wait`+1.
- R8: The timeout fires at most once per access. Its counter restarts from zero whenever the synchronized wait input goes high.
- R9: Writing ones to address 0x44 sets the matching enable bits. Writing ones to address 0x48 clears them. Reading either address returns the enable bits in positions 2:0.
- R10: The word at 0x4C reads as the raw flags ANDed with the enables. `irq_out` is the OR of those three masked bits.
- R11: If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_n_in | input | 1 | Asynchronous active-low wait input |
| ext_access | input | 1 | High while an extended access is in progress |
| max_wait | input | CNT_W | Limit on the wait cycles allowed during an access |
| trap_pulse | input | 1 | One-cycle line-trap event |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CNT_W = 8 and AW = 8. With these values the address decode is exact, and `max_wait` can be set to small limits of 5 and 10. Small limits let the bench pin down the exact edge on which a timeout fires within a few dozen cycles. They also let it show that the counter restarts: a partial stall followed by a release does not add up toward a timeout. The synchronizer latency is checked edge by edge on the wait-rise flag.

// File: rtl/wait_tmo_irq.sv
module wait_tmo_irq #(
  parameter int CNT_W = 16,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_n_in,
  input  logic             ext_access,
  input  logic [CNT_W-1:0] max_wait,
  input  logic             trap_pulse,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_out
);
  localparam logic [AW-1:0] A_RAW = AW'(32'h40);
  localparam logic [AW-1:0] A_SET = AW'(32'h44);
  localparam logic [AW-1:0] A_CLR = AW'(32'h48);
  localparam logic [AW-1:0] A_MSK = AW'(32'h4C);

  logic [2:0]       sync;
  logic [CNT_W-1:0] cnt;
  logic             fired;
  logic [2:0]       raw, en, masked;
  logic             wait_act, rise, tmo_hit, wr;
  logic [2:0]       sw_clr;
  logic             unused_wdata;

  assign wait_act = ~sync[1];
  assign rise     = sync[1] & ~sync[2];
  assign tmo_hit  = ext_access & wait_act & ~fired & (cnt == max_wait);
  assign wr       = reg_sel & reg_wr;
  assign sw_clr   = (wr && reg_addr == A_RAW) ? reg_wdata[2:0] : 3'b000;
  assign masked   = raw & en;
  assign irq_out  = |masked;
  assign unused_wdata = ^reg_wdata[31:3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], wait_n_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!ext_access) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!wait_act) begin
      cnt   <= '0;
    end else if (tmo_hit) begin
      fired <= 1'b1;
    end else if (!fired) begin
      cnt   <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) raw <= 3'b000;
    else        raw <= (raw & ~sw_clr) | {rise, trap_pulse, tmo_hit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          en <= 3'b000;
    else if (wr && reg_addr == A_SET)    en <= en | reg_wdata[2:0];
    else if (wr && reg_addr == A_CLR)    en <= en & ~reg_wdata[2:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RAW:        reg_rdata[2:0] = raw;
      A_SET, A_CLR: reg_rdata[2:0] = en;
      A_MSK:        reg_rdata[2:0] = masked;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

module wait_tmo_irq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_pulse,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq_out,
  input logic [2:0]    raw,
  input logic [2:0]    en,
  input logic          tmo_hit
);
  localparam logic [AW-1:0] C_RAW = AW'(32'h40);
  localparam logic [AW-1:0] C_CLR = AW'(32'h48);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (raw == 3'b000 && en == 3'b000 && !irq_out));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_addr == C_RAW && reg_wdata[1] && !trap_pulse) |=> !raw[1]);

  assert_set_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && !en[1]) |=> raw[1]);

  assert_trap_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |=> raw[1]);

  assert_timeout_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> raw[0]);

  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_addr == C_CLR) |=> ((en & $past(reg_wdata[2:0])) == 3'b000));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 3'b000) |-> !irq_out);

  assert_irq_raised_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[1] && en[1]) |-> irq_out);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && reg_sel && reg_wr && reg_addr == C_RAW && reg_wdata[1]) |=> raw[1]);
endmodule

bind wait_tmo_irq wait_tmo_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_pulse(trap_pulse), .reg_sel(reg_sel),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_out(irq_out), .raw(raw), .en(en), .tmo_hit(tmo_hit)
);

// File: tb/sim_wait_tmo_irq.sv
module sim_wait_tmo_irq;
  localparam int CNT_W = 8;
  localparam int AW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wait_n_in = 1'b1;
  logic             ext_access = 1'b0;
  logic [CNT_W-1:0] max_wait = 8'd5;
  logic             trap_pulse = 1'b0;
  logic             reg_sel = 1'b0;
  logic             reg_wr = 1'b0;
  logic [AW-1:0]    reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             irq_out;

  wait_tmo_irq #(.CNT_W(CNT_W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wait_n_in(wait_n_in), .ext_access(ext_access),
    .max_wait(max_wait), .trap_pulse(trap_pulse), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  ev_sample;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  initial forever begin
    item_t it;
    logic [31:0] act;
    @(ev_sample);
    #1;
    it  = q.pop_front();
    act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
    checks++;
    if (act !== it.exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
    end
  end

  task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> ev_sample;
    #2;
    reg_sel = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    -> ev_sample;
    #2;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    edges(3);
    @(negedge clk) rst_n = 1'b1;

    expect_rd(8'h40, 32'h0, "R1 raw after reset");
    expect_rd(8'h44, 32'h0, "R1 enables after reset");
    expect_irq(1'b0, "R1 irq after reset");

    @(negedge clk) trap_pulse = 1'b1;
    @(negedge clk) trap_pulse = 1'b0;
    expect_rd(8'h40, 32'h2, "R6 trap sets bit1");
    expect_rd(8'h4C, 32'h0, "R4 masked zero with enable off");
    expect_irq(1'b0, "R4 no irq with enable off");

    bus_wr(8'h40, 32'h0);
    expect_rd(8'h40, 32'h2, "R3 write zero keeps flag");
    bus_wr(8'h40, 32'hFFFF_FFF8);
    expect_rd(8'h40, 32'h2, "R2 upper bits read zero and ignore writes");

    bus_wr(8'h44, 32'h2);
    expect_rd(8'h48, 32'h2, "R9 enable set visible");
    expect_rd(8'h4C, 32'h2, "R10 masked word");
    expect_irq(1'b1, "R10 irq raised");
    bus_wr(8'h40, 32'h2);
    expect_rd(8'h40, 32'h0, "R3 w1c clears raw");
    expect_rd(8'h4C, 32'h0, "R3 w1c clears masked");
    expect_irq(1'b0, "R10 irq dropped");

    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h2; trap_pulse = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; trap_pulse = 1'b0;
    expect_rd(8'h40, 32'h2, "R11 set wins over clear");
    bus_wr(8'h40, 32'h2);

    @(negedge clk) wait_n_in = 1'b0;
    edges(4);
    expect_rd(8'h40, 32'h0, "R5 falling edge sets nothing");
    @(negedge clk) wait_n_in = 1'b1;
    edges(2);
    expect_rd(8'h40, 32'h0, "R5 not yet after two edges");
    edges(1);
    expect_rd(8'h40, 32'h4, "R5 set after third edge");
    bus_wr(8'h40, 32'h4);

    bus_wr(8'h44, 32'h1);
    @(negedge clk) wait_n_in = 1'b0;
    edges(4);
    @(negedge clk) ext_access = 1'b1;
    edges(5);
    expect_rd(8'h40, 32'h0, "R7 no timeout at max_wait edges");
    edges(1);
    expect_rd(8'h40, 32'h1, "R7 timeout at max_wait+1 edges");
    expect_irq(1'b1, "R10 irq from timeout");
    bus_wr(8'h40, 32'h1);
    edges(20);
    expect_rd(8'h40, 32'h0, "R8 single fire per access");
    bus_wr(8'h48, 32'h1);
    expect_irq(1'b0, "R9 enable clear drops irq");
    expect_rd(8'h44, 32'h2, "R9 enable clear leaves other bits");

    @(negedge clk) ext_access = 1'b0;
    max_wait = 8'd10;
    @(negedge clk) ext_access = 1'b1;
    edges(5);
    @(negedge clk) wait_n_in = 1'b1;
    edges(4);
    @(negedge clk) wait_n_in = 1'b0;
    edges(12);
    expect_rd(8'h40, 32'h4, "R8 counter restarted after release");
    edges(1);
    expect_rd(8'h40, 32'h5, "R7 full window after restart");
    @(negedge clk) ext_access = 1'b0;

    edges(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule